// File: doc/BRIEF.md
# Dual Timebase Prescaler

This block supplies two free-running timebase counters to a timer coprocessor. The first timebase advances at a rate set by two prescaler stages in series. A front stage divides the system clock by 4 (fast) or by 32 (slow). A binary stage then divides that rate by 1, 2, 4 or 8. Channel logic reads the count value. It can also use the one-cycle tick that marks each advance.

The second timebase takes its events from an external pin, after a two-flop synchronizer. In clock mode, each rising edge of the synchronized pin is one event. In gate mode, an internal divide-by-8 tick is counted only while the synchronized pin is high, so the counter accumulates the time the gate is open. The events pass through a binary stage with the same 1/2/4/8 encoding. All logic runs on the one system clock and uses clock enables. When a rate setting changes, the affected divider chain restarts, so the first period after the change is a full period.

Top module: `dual_timebase`

## Requirements
- R1: `fast_sel`=1 selects a front division of 4 and `fast_sel`=0 selects 32. With `tb1_rate`=00, timebase 1 advances once every 4 or every 32 system clocks.
- R2: `tb1_rate` codes 00, 01, 10 and 11 multiply the timebase 1 period by 1, 2, 4 and 8. This gives periods of 4/8/16/32 clocks with the fast front stage and 32/64/128/256 clocks with the slow one.
- R3: Each advance of `tb1_count` is by exactly one. It is shown by `tb1_tick` high for exactly that one cycle, and the count holds in every other cycle.
- R4: Both counters wrap from all ones to zero as an ordinary increment.
- R5: With `pin_gate_mode`=0, timebase 2 counts rising edges of `pin_in`. An edge sampled at clock edge k appears as an event at clock edge k+2. Every 2^`tb2_rate` events advance the count once.
- R6: With `pin_gate_mode`=1, an event occurs on every eighth system clock when the synchronized pin is high. Events are then divided by 2^`tb2_rate`, and nothing is counted while the pin is low.
- R7: `tb2_count` changes only by +1, with `tb2_tick` high in that cycle alone.
- R8: A change of {`fast_sel`,`tb1_rate`} restarts the timebase 1 dividers. A change of {`pin_gate_mode`,`tb2_rate`} restarts the timebase 2 dividers. No advance occurs at the clock edge where the change is seen, and the next advance comes one full period later.
- R9: A synchronous low `rst_n` clears both counts, both ticks, all dividers and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_sel | input | 1 | Front stage select: 1 divides by 4, 0 divides by 32 |
| tb1_rate | input | 2 | Timebase 1 binary stage code (divide by 2^code) |
| pin_in | input | 1 | Asynchronous external pin |
| pin_gate_mode | input | 1 | 0: pin is clock source; 1: pin gates the divide-by-8 tick |
| tb2_rate | input | 2 | Timebase 2 binary stage code (divide by 2^code) |
| tb1_count | output | CNT_W | Timebase 1 value |
| tb1_tick | output | 1 | One-cycle pulse with each timebase 1 advance |
| tb2_count | output | CNT_W | Timebase 2 value |
| tb2_tick | output | 1 | One-cycle pulse with each timebase 2 advance |

## Verification
A wrong divider state shows up at the ports as a tick one or more cycles early or late. A reference that tracks each period to the exact clock edge therefore catches it at the first advance after the fault, within one period of at most 256 clocks. A synchronizer or edge-detect fault shifts or drops timebase 2 events, and this is visible within two to three clock edges of a pin transition. A missed restart after a rate change moves the next tick off its full-period position. Comparing the count and the tick on every clock exposes all of these at the first divergent cycle.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic {
        PIN_AS_CLOCK = 1'b0,
        PIN_AS_GATE  = 1'b1
    } pin_role_e;

    typedef struct packed {
        logic       fast_sel;
        logic [1:0] tb1_rate;
        pin_role_e  role;
        logic [1:0] tb2_rate;
    } tbp_cfg_t;

    // Terminal value of a binary stage that divides by 2^code.
    function automatic logic [2:0] rate_last(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd0;
            2'b01:   return 3'd1;
            2'b10:   return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/tbp_modcnt.sv
module tbp_modcnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] last,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = en && !clr && (st_q.cnt == last);
        if (clr)
            st_d.cnt = '0;
        else if (en)
            st_d.cnt = (st_q.cnt == last) ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/tbp_sync.sv
module tbp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.sh = {st_q.sh[STAGES-1:0], pin};
        level   = st_q.sh[STAGES-1];
        rise    = st_q.sh[STAGES-1] && !st_q.sh[STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/tbp_counter.sv
module tbp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.cnt = step ? st_q.cnt + 1'b1 : st_q.cnt;
        st_d.stb = step;
        count    = st_q.cnt;
        tick     = st_q.stb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/dual_timebase.sv
module dual_timebase #(
    parameter int CNT_W       = 16,
    parameter int FAST_DIV    = 4,
    parameter int SLOW_DIV    = 32,
    parameter int GATE_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_sel,
    input  logic [1:0]       tb1_rate,
    input  logic             pin_in,
    input  logic             pin_gate_mode,
    input  logic [1:0]       tb2_rate,
    output logic [CNT_W-1:0] tb1_count,
    output logic             tb1_tick,
    output logic [CNT_W-1:0] tb2_count,
    output logic             tb2_tick
);
    import tbp_pkg::*;

    localparam int FRONT_W = $clog2(SLOW_DIV);
    localparam int GATE_W  = $clog2(GATE_DIV);

    typedef struct packed {
        tbp_cfg_t cfg;
    } st_t;

    st_t      st_d, st_q;
    tbp_cfg_t cfg_now;
    logic     restart1, restart2;
    logic [FRONT_W-1:0] front_last;
    logic     front_wrap, step1;
    logic     pin_level, pin_rise, gate_wrap, event2, step2;

    always_comb begin
        cfg_now  = '{fast_sel: fast_sel, tb1_rate: tb1_rate,
                     role: pin_role_e'(pin_gate_mode), tb2_rate: tb2_rate};
        st_d.cfg = cfg_now;
        restart1 = (cfg_now.fast_sel != st_q.cfg.fast_sel) ||
                   (cfg_now.tb1_rate != st_q.cfg.tb1_rate);
        restart2 = (cfg_now.role != st_q.cfg.role) ||
                   (cfg_now.tb2_rate != st_q.cfg.tb2_rate);
        front_last = fast_sel ? FRONT_W'(FAST_DIV - 1) : FRONT_W'(SLOW_DIV - 1);
        event2 = (cfg_now.role == PIN_AS_GATE) ? (gate_wrap && pin_level) : pin_rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.cfg <= cfg_now;
        else
            st_q <= st_d;
    end

    // Timebase 1: front stage then binary stage.
    tbp_modcnt #(.W(FRONT_W)) u_front (
        .clk(clk), .rst_n(rst_n), .clr(restart1), .en(1'b1),
        .last(front_last), .wrap(front_wrap));

    tbp_modcnt #(.W(3)) u_bin1 (
        .clk(clk), .rst_n(rst_n), .clr(restart1), .en(front_wrap),
        .last(rate_last(tb1_rate)), .wrap(step1));

    tbp_counter #(.CNT_W(CNT_W)) u_cnt1 (
        .clk(clk), .rst_n(rst_n), .step(step1),
        .count(tb1_count), .tick(tb1_tick));

    // Timebase 2: synchronized pin, gate tick, binary stage.
    tbp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in),
        .level(pin_level), .rise(pin_rise));

    tbp_modcnt #(.W(GATE_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .clr(restart2), .en(1'b1),
        .last(GATE_W'(GATE_DIV - 1)), .wrap(gate_wrap));

    tbp_modcnt #(.W(3)) u_bin2 (
        .clk(clk), .rst_n(rst_n), .clr(restart2), .en(event2),
        .last(rate_last(tb2_rate)), .wrap(step2));

    tbp_counter #(.CNT_W(CNT_W)) u_cnt2 (
        .clk(clk), .rst_n(rst_n), .step(step2),
        .count(tb2_count), .tick(tb2_tick));
endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fast_sel,
    input logic [1:0]       tb1_rate,
    input logic             pin_gate_mode,
    input logic [1:0]       tb2_rate,
    input logic [CNT_W-1:0] tb1_count,
    input logic             tb1_tick,
    input logic [CNT_W-1:0] tb2_count,
    input logic             tb2_tick
);
    localparam logic [CNT_W-1:0] ONE = 1;

    // R3
    tb1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb1_tick |-> tb1_count == $past(tb1_count) + ONE);
    // R3
    tb1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tb1_tick |-> $stable(tb1_count));
    // R1
    tb1_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb1_tick |=> !tb1_tick);
    // R7
    tb2_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb2_tick |-> tb2_count == $past(tb2_count) + ONE);
    // R7
    tb2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tb2_tick |-> $stable(tb2_count));
    // R8
    tb1_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_sel != $past(fast_sel) || tb1_rate != $past(tb1_rate)) |=> !tb1_tick);
    // R8
    tb2_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_gate_mode != $past(pin_gate_mode) || tb2_rate != $past(tb2_rate)) |=> !tb2_tick);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (tb1_count == '0 && tb2_count == '0 && !tb1_tick && !tb2_tick));
endmodule

bind dual_timebase tbp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .tb1_rate(tb1_rate),
    .pin_gate_mode(pin_gate_mode), .tb2_rate(tb2_rate),
    .tb1_count(tb1_count), .tb1_tick(tb1_tick),
    .tb2_count(tb2_count), .tb2_tick(tb2_tick));

// File: tb/sim_dual_timebase.sv
module sim_dual_timebase;
    localparam int W    = 10;
    localparam int MASK = (1 << W) - 1;

    logic clk = 0, rst_n = 0, fast_sel = 1, pin_in = 0, pin_gate_mode = 0;
    logic [1:0] tb1_rate = 0, tb2_rate = 0;
    logic [W-1:0] tb1_count, tb2_count;
    logic tb1_tick, tb2_tick;

    always #10 clk = ~clk;

    dual_timebase #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .tb1_rate(tb1_rate),
        .pin_in(pin_in), .pin_gate_mode(pin_gate_mode), .tb2_rate(tb2_rate),
        .tb1_count(tb1_count), .tb1_tick(tb1_tick),
        .tb2_count(tb2_count), .tb2_tick(tb2_tick));

    int checks = 0, fails = 0, cycles = 0;
    string req = "R9";

    // Behavioural reference: elapsed-clock accumulators per timebase.
    int m1 = 0, m2 = 0, a1 = 0, a2 = 0, a8 = 0;
    bit e1 = 0, e2 = 0, p1 = 0, p2 = 0, p3 = 0, ev;
    logic [2:0] prev1, prev2;
    int per1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; a1 = 0; a2 = 0; a8 = 0; e1 = 0; e2 = 0;
            p1 = 0; p2 = 0; p3 = 0;
        end else begin
            per1 = (fast_sel ? 4 : 32) * (1 << tb1_rate);
            e1 = 0;
            if ({fast_sel, tb1_rate} != prev1) a1 = 0;
            else begin
                a1++;
                if (a1 == per1) begin a1 = 0; m1 = (m1 + 1) & MASK; e1 = 1; end
            end
            ev = pin_gate_mode ? (a8 == 7 && p2) : (p2 && !p3);
            e2 = 0;
            if ({pin_gate_mode, tb2_rate} != prev2) begin a8 = 0; a2 = 0; end
            else begin
                a8 = (a8 + 1) % 8;
                if (ev) begin
                    a2++;
                    if (a2 == (1 << tb2_rate)) begin a2 = 0; m2 = (m2 + 1) & MASK; e2 = 1; end
                end
            end
            p3 = p2; p2 = p1; p1 = pin_in;
        end
        prev1 = {fast_sel, tb1_rate};
        prev2 = {pin_gate_mode, tb2_rate};
    end

    bit wrap1 = 0, wrap2 = 0;
    logic [W-1:0] last1 = 0, last2 = 0;

    always @(negedge clk) begin
        cycles++;
        checks += 2;
        if (tb1_count !== W'(m1) || tb1_tick !== e1) begin
            fails++;
            $display("FAIL %s tb1 actual cnt=%0d tick=%0b expected cnt=%0d tick=%0b",
                     req, tb1_count, tb1_tick, m1, e1);
        end
        if (tb2_count !== W'(m2) || tb2_tick !== e2) begin
            fails++;
            $display("FAIL %s tb2 actual cnt=%0d tick=%0b expected cnt=%0d tick=%0b",
                     req, tb2_count, tb2_tick, m2, e2);
        end
        if (last1 == W'(MASK) && tb1_count == 0) wrap1 = 1;
        if (last2 == W'(MASK) && tb2_count == 0) wrap2 = 1;
        last1 = tb1_count; last2 = tb2_count;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual cycles=%0d expected below 100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; step(4); rst_n = 1;
    endtask

    initial begin
        req = "R9";
        step(4);
        chk(tb1_count == 0 && tb2_count == 0 && !tb1_tick && !tb2_tick, "R9 reset", tb1_count, 0);
        rst_n = 1;
        // R1/R2: every front select and binary code.
        for (int f = 1; f >= 0; f--) begin
            for (int c = 0; c < 4; c++) begin
                req = "R1/R2 timebase 1 period";
                fast_sel = f[0]; tb1_rate = c[1:0];
                step((f ? 4 : 32) * (1 << c) * 3 + 5);
            end
        end
        // R8: rate change in mid period.
        req = "R8 restart";
        fast_sel = 1; tb1_rate = 2; step(10);
        tb1_rate = 1; step(5);
        tb1_rate = 3; step(70);
        pin_gate_mode = 1; tb2_rate = 0; pin_in = 1; step(13);
        tb2_rate = 2; step(100);
        // R5: pin as clock, irregular toggling.
        pin_gate_mode = 0;
        for (int c = 0; c < 4; c++) begin
            req = "R5/R7 clock mode";
            tb2_rate = c[1:0];
            for (int i = 0; i < 200; i++) begin
                if (i % ((i % 3) + 2) == 0) pin_in = ~pin_in;
                step(1);
            end
        end
        // R6: pin as gate, chunks of open and closed time.
        pin_gate_mode = 1;
        for (int c = 0; c < 4; c++) begin
            req = "R6/R7 gate mode";
            tb2_rate = c[1:0];
            for (int i = 0; i < 400; i++) begin
                pin_in = ((i / 37) % 3) != 1;
                step(1);
            end
        end
        // R4: wrap of both counters.
        req = "R4 wrap";
        do_reset();
        fast_sel = 1; tb1_rate = 0; pin_gate_mode = 0; tb2_rate = 0;
        step(2);
        for (int i = 0; i < 4300; i++) begin
            pin_in = ~pin_in;
            step(1);
        end
        chk(wrap1, "R4 tb1 wrap seen", wrap1, 1);
        chk(wrap2, "R4 tb2 wrap seen", wrap2, 1);
        // R9: reset mid-run clears everything.
        req = "R9";
        rst_n = 0; step(2);
        chk(tb1_count == 0 && tb2_count == 0, "R9 reset mid-run", tb1_count + tb2_count, 0);
        rst_n = 1; step(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule